// File: doc/BRIEF.md
# Token-Passing Readout Sender

This block is the sending end of a daisy-chained readout bus shared by several converter modules. When a conversion ends, it checks whether readout over the port is enabled and whether its word source holds data. If both hold, it raises a request and waits for the chain's enable token. While the token is present, it moves words out one at a time. Each word uses a four-phase exchange: the data word is driven, the strobe rises, the receiver answers with an acknowledge, the strobe drops, and the acknowledge is released. A guaranteed idle gap follows before the next word.

The block hands the token on through its pass output. An empty or disabled module forwards the token in the same cycle. A module that was busy forwards it once its last word has been fully acknowledged. A synchronous clear abandons any exchange at any time. All bus timings are counted in clock cycles: data-to-strobe setup, minimum strobe width, minimum acknowledge width and the inter-word gap. The defaults suit a 100 MHz clock, which keeps the word rate at or below 10 MHz.

Top module: `rdo_token_sender`

## Requirements
- R1: While reset is applied, request, strobe and data output are all low, and pass equals the token input.
- R2: The request rises in the cycle after a conversion-done pulse, but only if port-enable and source-valid were both high with that pulse. Otherwise the request stays low.
- R3: Pass follows the token in the same cycle whenever the request is low, and pass is low whenever the request is high.
- R4: The strobe and data outputs are zero unless both the token and the request are high. Dropping the token in the middle of a word masks them. Restoring the token brings back the same word.
- R5: The data word is on the bus for at least SETUP_CYC cycles before the strobe rises. It stays unchanged for as long as the strobe is high.
- R6: The strobe stays high for at least STB_MIN_CYC cycles and until a qualified acknowledge arrives. An acknowledge that stays high for fewer than ACK_MIN_CYC consecutive cycles is ignored.
- R7: After the acknowledge is released, the next strobe rises no earlier than GAP_CYC cycles later.
- R8: Words leave in the order the source offers them, one word per strobe. A word is taken from the source in a cycle where both src_valid_i and src_ready_o are high.
- R9: The request falls one cycle after the acknowledge of the word marked last is released, or when the source is empty at a word boundary. Pass then follows the token.
- R10: A clear sets request and strobe low in the next cycle and abandons the transfer. When a clear and a conversion-done pulse arrive in the same cycle, the clear wins and no request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clear_i | input | 1 | Synchronous abort of any transfer |
| conv_done_i | input | 1 | One-cycle pulse marking the end of a conversion |
| port_en_i | input | 1 | Readout over the bus is permitted |
| src_valid_i | input | 1 | Word source holds a word |
| src_data_i | input | DATA_W | Word offered by the source |
| src_last_i | input | 1 | Offered word is the final one of the block |
| src_ready_o | output | 1 | Offered word is taken this cycle |
| tok_i | input | 1 | Readout enable token from the chain |
| ack_i | input | 1 | Write acknowledge from the receiver |
| req_o | output | 1 | Readout request |
| strobe_o | output | 1 | Write strobe, data valid |
| data_o | output | DATA_W | Data bus |
| pass_o | output | 1 | Token handed to the next module |

## Verification
Clear is the function most likely to collide with another one, so the bench stresses it. In one case the bench raises clear together with a conversion-done pulse while a word is pending, and expects no request in the next cycle. In another it raises clear while a strobe is high, and expects request and strobe low on the following cycle with pass returning to the token. The token-drop case is handled in the same way: the token is removed while a strobe is high, and the bench requires masked outputs at once, then the identical word when the token returns.

// File: rtl/rdo_sender_pkg.sv
`timescale 1ns/1ps
package rdo_sender_pkg;

  typedef enum logic [2:0] {
    SND_IDLE    = 3'd0,
    SND_LOAD    = 3'd1,
    SND_SETUP   = 3'd2,
    SND_STROBE  = 3'd3,
    SND_RELEASE = 3'd4,
    SND_GAP     = 3'd5
  } snd_state_t;

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/rdo_reset_sync.sv
`timescale 1ns/1ps
module rdo_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/rdo_phase_timer.sv
`timescale 1ns/1ps
module rdo_phase_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart_i,
  input  logic             run_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             reached_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign reached_o = (cnt_q >= limit_i);
  assign cnt_en    = restart_i | (run_i & ~reached_o);

  always_comb begin
    cnt_d = cnt_q;
    if (restart_i)   cnt_d = '0;
    else if (cnt_en) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/rdo_ack_qualifier.sv
`timescale 1ns/1ps
module rdo_ack_qualifier #(
  parameter int ACK_MIN_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ack_i,
  output logic ack_ok_o
);
  localparam int RUN_W = $clog2(ACK_MIN_CYC + 1);
  localparam logic [RUN_W-1:0] RUN_SAT = RUN_W'(ACK_MIN_CYC - 1);

  logic [RUN_W-1:0] run_q, run_d;

  always_comb begin
    if (!ack_i)               run_d = '0;
    else if (run_q != RUN_SAT) run_d = run_q + 1'b1;
    else                      run_d = run_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= run_d;
  end

  assign ack_ok_o = ack_i & (run_q == RUN_SAT);
endmodule

// File: rtl/rdo_word_latch.sv
`timescale 1ns/1ps
module rdo_word_latch #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              drop_i,
  input  logic              drive_i,
  input  logic [DATA_W-1:0] word_i,
  output logic [DATA_W-1:0] data_o
);
  logic [DATA_W-1:0] word_q;
  logic              live_q, live_d;

  always_comb begin
    live_d = live_q;
    if (drop_i)      live_d = 1'b0;
    else if (load_i) live_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      live_q <= 1'b0;
    end else begin
      live_q <= live_d;
      if (load_i) word_q <= word_i;
    end
  end

  assign data_o = (live_q & drive_i) ? word_q : '0;
endmodule

// File: rtl/rdo_token_sender.sv
`timescale 1ns/1ps
module rdo_token_sender
  import rdo_sender_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int SETUP_CYC   = 1,
  parameter int STB_MIN_CYC = 4,
  parameter int ACK_MIN_CYC = 3,
  parameter int GAP_CYC     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              conv_done_i,
  input  logic              port_en_i,
  input  logic              src_valid_i,
  input  logic [DATA_W-1:0] src_data_i,
  input  logic              src_last_i,
  output logic              src_ready_o,
  input  logic              tok_i,
  input  logic              ack_i,
  output logic              req_o,
  output logic              strobe_o,
  output logic [DATA_W-1:0] data_o,
  output logic              pass_o
);
  localparam int unsigned MAX_WAIT = max3(SETUP_CYC, STB_MIN_CYC, GAP_CYC);
  localparam int CNT_W = $clog2(MAX_WAIT + 1);

  logic             rst_core_n;
  snd_state_t       state_q, state_d;
  logic             req_q, req_d;
  logic             stb_q, stb_d;
  logic             last_q;
  logic             load_w, drop_w, take_w;
  logic             reached_w, ack_ok_w, drive_w;
  logic [CNT_W-1:0] limit_w;

  rdo_reset_sync i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  rdo_ack_qualifier #(.ACK_MIN_CYC(ACK_MIN_CYC)) i_ack_qual (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .ack_i    (ack_i),
    .ack_ok_o (ack_ok_w)
  );

  always_comb begin
    case (state_q)
      SND_SETUP:  limit_w = CNT_W'(SETUP_CYC - 1);
      SND_STROBE: limit_w = CNT_W'(STB_MIN_CYC - 1);
      SND_GAP:    limit_w = CNT_W'(GAP_CYC - 1);
      default:    limit_w = '0;
    endcase
  end

  rdo_phase_timer #(.CNT_W(CNT_W)) i_timer (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .restart_i (state_d != state_q),
    .run_i     (tok_i),
    .limit_i   (limit_w),
    .reached_o (reached_w)
  );

  // next-state process
  always_comb begin
    state_d = state_q;
    req_d   = req_q;
    stb_d   = stb_q;
    load_w  = 1'b0;
    drop_w  = 1'b0;
    take_w  = 1'b0;
    case (state_q)
      SND_IDLE: begin
        if (conv_done_i && port_en_i && src_valid_i) begin
          req_d   = 1'b1;
          state_d = SND_LOAD;
        end
      end
      SND_LOAD: begin
        if (tok_i) begin
          if (src_valid_i) begin
            take_w  = 1'b1;
            load_w  = 1'b1;
            state_d = SND_SETUP;
          end else begin
            req_d   = 1'b0;
            state_d = SND_IDLE;
          end
        end
      end
      SND_SETUP: begin
        if (tok_i && reached_w) begin
          stb_d   = 1'b1;
          state_d = SND_STROBE;
        end
      end
      SND_STROBE: begin
        if (tok_i && reached_w && ack_ok_w) begin
          stb_d   = 1'b0;
          state_d = SND_RELEASE;
        end
      end
      SND_RELEASE: begin
        if (tok_i && !ack_i) begin
          drop_w = 1'b1;
          if (last_q) begin
            req_d   = 1'b0;
            state_d = SND_IDLE;
          end else begin
            state_d = SND_GAP;
          end
        end
      end
      SND_GAP: begin
        if (tok_i && reached_w) state_d = SND_LOAD;
      end
      default: state_d = SND_IDLE;
    endcase
    if (clear_i) begin
      state_d = SND_IDLE;
      req_d   = 1'b0;
      stb_d   = 1'b0;
      load_w  = 1'b0;
      take_w  = 1'b0;
      drop_w  = 1'b1;
    end
  end

  // register process
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      state_q <= SND_IDLE;
      req_q   <= 1'b0;
      stb_q   <= 1'b0;
      last_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      req_q   <= req_d;
      stb_q   <= stb_d;
      if (load_w) last_q <= src_last_i;
    end
  end

  assign drive_w = tok_i & req_q;

  rdo_word_latch #(.DATA_W(DATA_W)) i_word (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .load_i  (load_w),
    .drop_i  (drop_w),
    .drive_i (drive_w),
    .word_i  (src_data_i),
    .data_o  (data_o)
  );

  assign src_ready_o = take_w;
  assign req_o       = req_q;
  assign strobe_o    = stb_q & drive_w;
  assign pass_o      = tok_i & ~req_q;
endmodule

// File: rtl/rdo_token_sender_chk.sv
`timescale 1ns/1ps
module rdo_token_sender_chk #(
  parameter int DATA_W  = 16,
  parameter int GAP_CYC = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clear_i,
  input logic              conv_done_i,
  input logic              port_en_i,
  input logic              src_valid_i,
  input logic              tok_i,
  input logic              ack_i,
  input logic              req_o,
  input logic              strobe_o,
  input logic              pass_o,
  input logic [DATA_W-1:0] data_o,
  input logic              stb_q
);
  localparam int GW = $clog2(GAP_CYC + 4) + 1;
  logic [GW-1:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           gap_q <= '1;
    else if (ack_i)       gap_q <= '0;
    else if (gap_q != '1) gap_q <= gap_q + 1'b1;
  end

  // R2
  req_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_o) |-> $past(conv_done_i) && $past(port_en_i) && $past(src_valid_i) && !$past(clear_i));

  // R3
  pass_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |-> !pass_o);

  // R4
  strobe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_o || data_o != '0) |-> (tok_i && req_o));

  // R5
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_o && $past(strobe_o)) |-> $stable(data_o));

  // R6
  stb_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(stb_q) && !$past(clear_i)) |-> $past(ack_i));

  // R7
  gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stb_q) |-> (gap_q >= GW'(GAP_CYC)));

  // R10
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (!req_o && !strobe_o));
endmodule

bind rdo_token_sender rdo_token_sender_chk #(.DATA_W(DATA_W), .GAP_CYC(GAP_CYC)) i_chk (
  .clk         (clk),
  .rst_n       (rst_core_n),
  .clear_i     (clear_i),
  .conv_done_i (conv_done_i),
  .port_en_i   (port_en_i),
  .src_valid_i (src_valid_i),
  .tok_i       (tok_i),
  .ack_i       (ack_i),
  .req_o       (req_o),
  .strobe_o    (strobe_o),
  .pass_o      (pass_o),
  .data_o      (data_o),
  .stb_q       (stb_q)
);

// File: tb/test_rdo_token_sender.sv
`timescale 1ns/1ps
module test_rdo_token_sender;
  localparam int DW      = 16;
  localparam int SETUP   = 1;
  localparam int STB_MIN = 4;
  localparam int ACK_MIN = 3;
  localparam int GAP     = 5;

  logic          clk = 1'b0;
  logic          rst_n, clear_i, conv_done_i, port_en_i;
  logic          src_valid_i, src_last_i, src_ready_o;
  logic [DW-1:0] src_data_i, data_o;
  logic          tok_i, ack_i, req_o, strobe_o, pass_o;

  always #4 clk = ~clk;

  rdo_token_sender #(.DATA_W(DW), .SETUP_CYC(SETUP), .STB_MIN_CYC(STB_MIN),
                     .ACK_MIN_CYC(ACK_MIN), .GAP_CYC(GAP)) i_rdo_token_sender (
    .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .conv_done_i(conv_done_i),
    .port_en_i(port_en_i), .src_valid_i(src_valid_i), .src_data_i(src_data_i),
    .src_last_i(src_last_i), .src_ready_o(src_ready_o), .tok_i(tok_i), .ack_i(ack_i),
    .req_o(req_o), .strobe_o(strobe_o), .data_o(data_o), .pass_o(pass_o));

  int checks = 0, errors = 0, step_no = 0, last_drop = 0;
  logic [DW-1:0] words[$];
  logic [DW-1:0] rx[$];
  int  widx = 0, wlen = 0;
  bit  src_on = 0, took = 0, auto_ack = 0;
  int  rx_phase = 0, rx_cnt = 0;
  bit  prev_stb = 0, prev_tok = 0, gap_armed = 0;
  int  stb_run = 0, gap_run = 0;
  logic [DW-1:0] held = '0, prev_data = '0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic void src_update();
    src_valid_i = src_on && (widx < wlen);
    src_data_i  = src_valid_i ? words[widx] : '0;
    src_last_i  = src_valid_i && (widx == wlen - 1);
  endfunction

  task automatic step();
    #1;
    took = src_ready_o && src_valid_i;
    @(posedge clk);
    #2;
    step_no++;
    if (took) widx++;
    // monitor
    if (strobe_o && !prev_stb) begin
      stb_run = 1;
      held = data_o;
      if (prev_tok) chk(prev_data == data_o, "R5 setup", prev_data, data_o);
      if (gap_armed) chk(gap_run >= GAP, "R7 gap", gap_run, GAP);
      gap_armed = 0;
    end else if (strobe_o) begin
      stb_run++;
      chk(data_o == held, "R5 hold", data_o, held);
    end else begin
      if (prev_stb && ack_i) chk(stb_run >= STB_MIN, "R6 width", stb_run, STB_MIN);
      if (gap_armed) gap_run++;
    end
    prev_stb = strobe_o;
    prev_tok = tok_i;
    prev_data = data_o;
    // receiver
    if (auto_ack) begin
      case (rx_phase)
        0: if (strobe_o) begin rx_cnt = $urandom_range(0, 2); rx_phase = 1; end
        1: if (rx_cnt == 0) begin
             ack_i = 1'b1; rx.push_back(data_o);
             rx_cnt = ACK_MIN + $urandom_range(0, 2); rx_phase = 2;
           end else rx_cnt--;
        default: begin
          if (rx_cnt > 0) rx_cnt--;
          if (rx_cnt == 0 && !strobe_o) begin
            ack_i = 1'b0; gap_run = 0; gap_armed = 1; last_drop = step_no; rx_phase = 0;
          end
        end
      endcase
    end
    src_update();
  endtask

  task automatic start_block(input int n);
    words.delete(); rx.delete();
    for (int i = 0; i < n; i++) words.push_back(DW'($urandom));
    widx = 0; wlen = n; src_on = 1; gap_armed = 0; rx_phase = 0;
    port_en_i = 1'b1; src_update();
    conv_done_i = 1'b1;
    step();
    conv_done_i = 1'b0;
    chk(req_o == 1'b1, "R2 request", req_o, 1);
  endtask

  task automatic finish_block(input int n, input bit cmp);
    int guard = 0;
    while (req_o && guard < 600) begin
      step(); guard++;
      chk(pass_o == (tok_i && !req_o), "R3 pass", pass_o, tok_i && !req_o);
    end
    chk(guard < 600, "R9 request released", guard, 600);
    if (cmp) chk(step_no == last_drop + 1, "R9 drop timing", step_no, last_drop + 1);
    chk(pass_o == tok_i, "R9 pass after block", pass_o, tok_i);
    if (cmp) begin
      chk(rx.size() == n, "R8 word count", rx.size(), n);
      for (int i = 0; i < n && i < rx.size(); i++)
        chk(rx[i] == words[i], "R8 word order", rx[i], words[i]);
    end
    auto_ack = 0; ack_i = 1'b0; rx_phase = 0; src_on = 0; src_update();
  endtask

  task automatic wait_strobe();
    int g = 0;
    while (!strobe_o && g < 100) begin step(); g++; end
  endtask

  initial begin
    void'($urandom(32'h1F3A));
    rst_n = 1'b0; clear_i = 0; conv_done_i = 0; port_en_i = 0;
    tok_i = 0; ack_i = 0; src_update();
    for (int i = 0; i < 3; i++) step();
    // R1 reset state
    chk(req_o == 0, "R1 req", req_o, 0);
    chk(strobe_o == 0, "R1 strobe", strobe_o, 0);
    chk(data_o == 0, "R1 data", data_o, 0);
    chk(pass_o == 0, "R1 pass low", pass_o, 0);
    tok_i = 1'b1; #1;
    chk(pass_o == 1, "R1 pass follows token", pass_o, 1);
    tok_i = 1'b0;
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) step();

    // R2/R3: port disabled, empty pass-through
    words = '{16'h1234}; widx = 0; wlen = 1; src_on = 1; src_update();
    port_en_i = 0; conv_done_i = 1; step(); conv_done_i = 0;
    chk(req_o == 0, "R2 port disabled", req_o, 0);
    tok_i = 1; #1;
    chk(pass_o == 1, "R3 empty pass", pass_o, 1);
    step(); tok_i = 0;
    // R2: no valid data
    src_on = 0; src_update(); port_en_i = 1; conv_done_i = 1; step(); conv_done_i = 0;
    chk(req_o == 0, "R2 no data", req_o, 0);

    // R4: token withheld while request on
    start_block(2);
    tok_i = 1; #1; chk(pass_o == 0, "R3 pass blocked", pass_o, 0); tok_i = 0;
    for (int i = 0; i < 5; i++) begin
      step();
      chk(strobe_o == 0 && data_o == 0, "R4 no token", {strobe_o, data_o}, 0);
    end
    tok_i = 1; auto_ack = 1;
    finish_block(2, 1);
    tok_i = 0; step();

    // R4: token dropped mid-strobe, same word returns
    start_block(1);
    tok_i = 1; wait_strobe();
    tok_i = 0; step();
    chk(strobe_o == 0, "R4 strobe masked", strobe_o, 0);
    chk(data_o == 0, "R4 data masked", data_o, 0);
    tok_i = 1; step();
    chk(strobe_o == 1, "R4 strobe back", strobe_o, 1);
    chk(data_o == words[0], "R4 same word", data_o, words[0]);
    auto_ack = 1;
    finish_block(1, 1);
    tok_i = 0; step();

    // R6: short acknowledge ignored
    start_block(1);
    tok_i = 1; wait_strobe();
    ack_i = 1; step(); ack_i = 0;
    for (int i = 0; i < 4; i++) step();
    chk(strobe_o == 1, "R6 short ack ignored", strobe_o, 1);
    auto_ack = 1;
    finish_block(1, 1);
    tok_i = 0; step();

    // R10: clear during strobe
    start_block(3);
    tok_i = 1; wait_strobe();
    clear_i = 1; step(); clear_i = 0;
    chk(req_o == 0, "R10 clear req", req_o, 0);
    chk(strobe_o == 0, "R10 clear strobe", strobe_o, 0);
    chk(pass_o == 1, "R10 pass after clear", pass_o, 1);
    src_on = 0; src_update(); tok_i = 0; step();

    // R10: clear and conversion-done together
    words = '{16'hBEEF}; widx = 0; wlen = 1; src_on = 1; src_update();
    clear_i = 1; conv_done_i = 1; step(); clear_i = 0; conv_done_i = 0;
    chk(req_o == 0, "R10 clear wins", req_o, 0);
    src_on = 0; src_update(); step();

    // random blocks
    for (int b = 0; b < 12; b++) begin
      int n;
      n = $urandom_range(1, 6);
      start_block(n);
      for (int k = $urandom_range(0, 3); k > 0; k--) step();
      tok_i = 1; auto_ack = 1;
      finish_block(n, 1);
      tok_i = 0; step();
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    checks++; errors++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule